// File: doc/BRIEF.md
# Packed Saturating Add/Subtract Unit

This block adds or subtracts two 64-bit operands as a set of independent lanes. A size input splits the word at run time into eight byte lanes, four word lanes or two doubleword lanes. No carry or borrow crosses from one lane into the next. A mode input selects how each lane handles overflow: it can wrap modulo the lane width, clamp to the signed range, or clamp to the unsigned range.

The operands are captured on a cycle in which `inValid` is high. The lane results appear on `result` one clock later, with `outValid` high for that one cycle. `result` keeps its value until the next accepted operation. The unit produces no condition flags. Saturation applies only to byte and word lanes. Doubleword lanes always wrap, whatever mode is requested.

Encodings:
- `laneSize`: 0 selects bytes, 1 selects words, and 2 or 3 select doublewords.
- `satMode`: 0 selects wraparound, 1 selects signed saturation, 2 selects unsigned saturation, and 3 selects wraparound.
- `opSub`: 1 selects A minus B and 0 selects A plus B.

Top module: `packed_addsub`

## Requirements
- R1: With `laneSize`=0 and wraparound mode, each of the eight bytes of `result` is (A byte ± B byte) mod 256, and a carry or borrow out of one byte never changes the byte above it.
- R2: With `laneSize`=1 and wraparound mode, each of the four 16-bit lanes is (A lane ± B lane) mod 65536, computed independently of its neighbours.
- R3: With `laneSize`=2 or 3, each 32-bit lane is (A lane ± B lane) mod 2^32 in every `satMode`, so a saturation request at this size returns the wrapped value.
- R4: With `satMode`=1 at byte or word size, a lane whose true signed result exceeds the range gives 0x7F or 0x7FFF, and one below the range gives 0x80 or 0x8000.
- R5: With `satMode`=2 and `opSub`=0 at byte or word size, a lane whose unsigned sum exceeds the lane width gives all ones.
- R6: With `satMode`=2 and `opSub`=1 at byte or word size, a lane in which B is greater than A gives zero.
- R7: `outValid` is high in exactly the cycle after a cycle with `inValid` high, and low otherwise. On cycles without `inValid`, `result` holds its previous value whatever the other inputs do.
- R8: After reset, `outValid` is 0 and `result` is 0.
- R9: Lanes that do not overflow give the exact value in the saturating modes, and a lane that saturates does not change any other lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operands and controls are valid this cycle |
| opSub | input | 1 | 1 = subtract B from A, 0 = add |
| laneSize | input | 2 | 0 byte, 1 word, 2/3 doubleword |
| satMode | input | 2 | 0 wrap, 1 signed saturate, 2 unsigned saturate, 3 wrap |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| outValid | output | 1 | Result valid, one cycle after inValid |
| result | output | 64 | Registered lane results |

## Verification
The hardest situation to reach is a mixed word: some lanes clamp in opposite directions while their neighbours stay in range, all in the same operation. Uniform random operands seldom put a lane exactly on a range edge. The random stimulus therefore draws each lane byte from a biased set of edge values (0x00, 0x01, 0x7F, 0x80, 0xFE, 0xFF) as well as from the full range. Directed vectors also pin down carry isolation, where a lane of all ones plus one must not ripple into the next lane.

// File: rtl/pas_pkg.sv
package pas_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned NBYTES = DATA_W / 8;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_DWALT = 2'd3
  } laneSize_e;

  typedef enum logic [1:0] {
    MD_WRAP   = 2'd0,
    MD_SSAT   = 2'd1,
    MD_USAT   = 2'd2,
    MD_WRAP2  = 2'd3
  } satMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              load;
    logic              isSub;
    logic              satSigned;
    logic              satUnsigned;
    logic              wordLanes;
    logic [NBYTES-2:0] laneBreak;   // bit i: lane boundary between byte i and i+1
  } pasCtrl_t;
endpackage

// File: rtl/pas_control.sv
module pas_control
  import pas_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic       opSub,
  input  logic [1:0] laneSize,
  input  logic [1:0] satMode,
  output pasCtrl_t   ctrl,
  output logic       outValid
);
  laneSize_e sizeSel;
  satMode_e  modeSel;
  logic      satAllowed;

  assign sizeSel    = laneSize_e'(laneSize);
  assign modeSel    = satMode_e'(satMode);
  assign satAllowed = (sizeSel == SZ_BYTE) || (sizeSel == SZ_WORD);

  always_comb begin
    ctrl             = '0;
    ctrl.load        = inValid;
    ctrl.isSub       = opSub;
    ctrl.wordLanes   = (sizeSel == SZ_WORD);
    ctrl.satSigned   = satAllowed && (modeSel == MD_SSAT);
    ctrl.satUnsigned = satAllowed && (modeSel == MD_USAT);
    for (int i = 0; i < NBYTES - 1; i++) begin
      unique case (sizeSel)
        SZ_BYTE:  ctrl.laneBreak[i] = 1'b1;
        SZ_WORD:  ctrl.laneBreak[i] = (i % 2) == 1;
        default:  ctrl.laneBreak[i] = (i % 4) == 3;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inValid;
  end
endmodule

// File: rtl/pas_datapath.sv
module pas_datapath
  import pas_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  pasCtrl_t          ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result
);
  logic [NBYTES-1:0]  carryOut;
  logic [NBYTES-1:0]  ovfSigned;
  logic [NBYTES-1:0]  ovfUnsigned;
  logic [DATA_W-1:0]  sumRaw;
  logic [DATA_W-1:0]  laneOut;

  // byte slices of the adder with a breakable carry chain
  for (genvar i = 0; i < NBYTES; i++) begin : g_slice
    logic [7:0] aByte, bEff;
    logic       cin;
    logic [8:0] sum9;
    assign aByte = opA[8*i +: 8];
    assign bEff  = ctrl.isSub ? ~opB[8*i +: 8] : opB[8*i +: 8];
    if (i == 0) begin : g_first
      assign cin = ctrl.isSub;
    end else begin : g_rest
      assign cin = ctrl.laneBreak[i-1] ? ctrl.isSub : carryOut[i-1];
    end
    assign sum9             = {1'b0, aByte} + {1'b0, bEff} + {8'd0, cin};
    assign carryOut[i]      = sum9[8];
    assign sumRaw[8*i +: 8] = sum9[7:0];
    assign ovfSigned[i]     = (aByte[7] == bEff[7]) && (sum9[7] != aByte[7]);
    assign ovfUnsigned[i]   = ctrl.isSub ? ~sum9[8] : sum9[8];
  end

  // per-byte clamp selection using the lane's top byte
  for (genvar i = 0; i < NBYTES; i++) begin : g_clamp
    localparam int unsigned TOPW = i | 1;
    logic isTop, hit, negDir;
    logic [7:0] fill;
    always_comb begin
      isTop  = ctrl.wordLanes ? (i == TOPW) : 1'b1;
      if (ctrl.wordLanes) begin
        hit    = ctrl.satSigned ? ovfSigned[TOPW] : ovfUnsigned[TOPW];
        negDir = opA[8*TOPW + 7];
      end else begin
        hit    = ctrl.satSigned ? ovfSigned[i] : ovfUnsigned[i];
        negDir = opA[8*i + 7];
      end
      if (ctrl.satSigned)
        fill = isTop ? (negDir ? 8'h80 : 8'h7F) : (negDir ? 8'h00 : 8'hFF);
      else
        fill = ctrl.isSub ? 8'h00 : 8'hFF;
      laneOut[8*i +: 8] = ((ctrl.satSigned || ctrl.satUnsigned) && hit)
                          ? fill : sumRaw[8*i +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         result <= '0;
    else if (ctrl.load) result <= laneOut;
  end
endmodule

// File: rtl/packed_addsub.sv
module packed_addsub
  import pas_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic              opSub,
  input  logic [1:0]        laneSize,
  input  logic [1:0]        satMode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              outValid,
  output logic [DATA_W-1:0] result
);
  pasCtrl_t ctrl;

  pas_control u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .opSub(opSub),
    .laneSize(laneSize), .satMode(satMode), .ctrl(ctrl), .outValid(outValid)
  );

  pas_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .opA(opA), .opB(opB), .result(result)
  );
endmodule

// File: rtl/pas_checker.sv
module pas_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        inValid,
  input logic        opSub,
  input logic [1:0]  laneSize,
  input logic [1:0]  satMode,
  input logic [63:0] opA,
  input logic [63:0] opB,
  input logic        outValid,
  input logic [63:0] result
);
  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);

  // R7
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> $stable(result));

  // R3
  dword_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && laneSize[1]) |=>
      result == ($past(opSub)
        ? {32'($past(opA[63:32]) - $past(opB[63:32])), 32'($past(opA[31:0]) - $past(opB[31:0]))}
        : {32'($past(opA[63:32]) + $past(opB[63:32])), 32'($past(opA[31:0]) + $past(opB[31:0]))}));

  // R5
  usat_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && laneSize == 2'd0 && satMode == 2'd2 && !opSub) |=>
      result[7:0] >= $past(opA[7:0]));

  // R6
  usat_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && laneSize == 2'd0 && satMode == 2'd2 && opSub) |=>
      result[7:0] <= $past(opA[7:0]));

  // R8
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reset_state_chk: assert (outValid == 1'b0 && result == 64'd0);
    end
  end
endmodule

bind packed_addsub pas_checker u_chk (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .opSub(opSub),
  .laneSize(laneSize), .satMode(satMode), .opA(opA), .opB(opB),
  .outValid(outValid), .result(result)
);

// File: tb/sim_packed_addsub.sv
`timescale 1ns/1ps
module sim_packed_addsub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic        opSub = 1'b0;
  logic [1:0]  laneSize = 2'd0;
  logic [1:0]  satMode = 2'd0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic        outValid;
  logic [63:0] result;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  packed_addsub u0 (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .opSub(opSub),
    .laneSize(laneSize), .satMode(satMode), .opA(opA), .opB(opB),
    .outValid(outValid), .result(result)
  );

  function automatic logic [63:0] refCalc(logic [63:0] a, logic [63:0] b,
                                          logic sub, logic [1:0] sz, logic [1:0] md);
    int w;
    logic [63:0] out;
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    out = '0;
    for (int k = 0; k < 64 / w; k++) begin
      longint mask, half, x, y, r, sx, sy;
      mask = (longint'(1) <<< w) - 1;
      half = longint'(1) <<< (w - 1);
      x = longint'((a >> (k * w))) & mask;
      y = longint'((b >> (k * w))) & mask;
      r = sub ? x - y : x + y;
      if (w < 32 && md == 2'd1) begin
        sx = (x >= half) ? x - (mask + 1) : x;
        sy = (y >= half) ? y - (mask + 1) : y;
        r = sub ? sx - sy : sx + sy;
        if (r > half - 1) r = half - 1;
        if (r < -half) r = -half;
      end else if (w < 32 && md == 2'd2) begin
        if (r > mask) r = mask;
        if (r < 0) r = 0;
      end
      out = out | (64'(r & mask) << (k * w));
    end
    return out;
  endfunction

  function automatic string tagFor(logic [1:0] sz, logic [1:0] md, logic sub);
    if (sz[1]) return "R3";
    if (md == 2'd1) return "R4/R9";
    if (md == 2'd2) return sub ? "R6/R9" : "R5/R9";
    return (sz == 2'd0) ? "R1" : "R2";
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, check one cycle later at negedge
  task automatic runOp(logic [63:0] a, logic [63:0] b, logic sub,
                       logic [1:0] sz, logic [1:0] md, string tag);
    @(negedge clk);
    inValid = 1'b1; opA = a; opB = b; opSub = sub; laneSize = sz; satMode = md;
    @(negedge clk);
    inValid = 1'b0;
    check({tag, " outValid"}, {63'd0, outValid}, 64'd1);
    check(tag, result, refCalc(a, b, sub, sz, md));
  endtask

  function automatic logic [7:0] edgeByte();
    logic [7:0] vals [6] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFE, 8'hFF};
    if ($urandom_range(1, 0) == 1) return vals[$urandom_range(5, 0)];
    return 8'($urandom);
  endfunction

  function automatic logic [63:0] edgeWord();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[8*i +: 8] = edgeByte();
    return v;
  endfunction

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 outValid", {63'd0, outValid}, 64'd0);
    check("R8 result", result, 64'd0);
    @(negedge clk); rst_n = 1'b1;

    // R1 carry isolation between bytes
    runOp(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 1'b0, 2'd0, 2'd0, "R1");
    runOp(64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101, 1'b1, 2'd0, 2'd0, "R1");
    // R2 word isolation
    runOp(64'h00FF_FFFF_00FF_FFFF, 64'h0000_0001_0000_0001, 1'b0, 2'd1, 2'd0, "R2");
    // R3 saturation requested at dword returns wrap
    runOp(64'hFFFF_FFFF_7FFF_FFFF, 64'h0000_0001_0000_0001, 1'b0, 2'd2, 2'd1, "R3");
    runOp(64'h0000_0000_8000_0000, 64'h0000_0001_0000_0001, 1'b1, 2'd3, 2'd2, "R3");
    // R4 signed clamps both ways, with untouched neighbours (R9)
    runOp(64'h7F80_1020_7F80_0000, 64'h0101_0101_01FF_0000, 1'b0, 2'd0, 2'd1, "R4");
    runOp(64'h8000_7FFF_1234_0000, 64'h0001_FFFF_0001_0000, 1'b1, 2'd1, 2'd1, "R4");
    // R5 unsigned add overflow
    runOp(64'hFF10_FFFF_0000_0000, 64'h0110_0001_0000_0000, 1'b0, 2'd0, 2'd2, "R5");
    // R6 unsigned subtract borrow
    runOp(64'h0010_0000_0005_1234, 64'h0120_0001_0006_1234, 1'b1, 2'd1, 2'd2, "R6");

    // R7 result held while inValid is low
    held = result;
    @(negedge clk);
    opA = 64'h1234_5678_9ABC_DEF0; opB = 64'h0F0F_0F0F_0F0F_0F0F; opSub = 1'b1;
    @(negedge clk);
    check("R7 idle outValid", {63'd0, outValid}, 64'd0);
    check("R7 hold", result, held);
    @(negedge clk);
    check("R7 single pulse", {63'd0, outValid}, 64'd0);

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [1:0] sz, md;
      logic sub;
      sz  = 2'($urandom_range(3, 0));
      md  = 2'($urandom_range(3, 0));
      sub = 1'($urandom_range(1, 0));
      runOp(edgeWord(), edgeWord(), sub, sz, md, tagFor(sz, md, sub));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule